// File: doc/BRIEF.md
# Quadrature Up/Down Counter/Timer

This block holds two 8-bit counting lanes that either run on their own or join into one 16-bit counter. Each lane is set to one of four count sources. It can count internal clock ticks through a small divide-select prescaler. It can count rising edges of an event input, with the direction taken from a level input. It can decode two quadrature phase inputs at double resolution, or decode them at quadruple resolution.

Software sets the block up through a narrow write port. That port holds one control word per lane, a shared 16-bit compare value, a clear command and a flag acknowledge. All four external inputs pass through a two-flop synchronizer and one edge register before they are decoded.

When the lanes are joined, the low lane's carry or borrow steps the high lane in the same clock edge. The 16-bit value therefore moves in whole steps. A compare hit sets a sticky flag and can force the count to zero. Wrap-around in either direction sets its own sticky flag. A separate sticky flag reports a double-bit jump on the phase inputs in quadruple mode.

Top module: `updn_counter_unit`

## Requirements
- R1: After reset the count is 0000h and every flag output is 0.
- R2: In timer mode (mode code 0, run bit 3 set) a lane adds one every 4^div clocks, where div is control bits [5:4]. The first step lands 4^div clock edges after the control write. Writing a control word restarts the lane's prescaler.
- R3: In event mode (mode code 1) each rising edge of `cnt_in` adds one when `dir_in` is 1 and subtracts one when it is 0. A change on `dir_in` alone leaves the count as it is.
- R4: In double-resolution phase mode (mode code 2) every edge of `phase_a` steps the count. The step is up when the new level of `phase_a` equals `phase_b`, and down otherwise.
- R5: In quadruple-resolution phase mode (mode code 3) every single-bit change of the pair {phase_a, phase_b} steps the count. The sequence 00, 01, 11, 10 counts up and the reverse order counts down.
- R6: In quadruple mode a change of both phase bits in one sample leaves the count unchanged and sets the sticky `flag_phase`.
- R7: An input change reaches the count on the third rising clock edge after it is applied. After two edges the count is still unchanged.
- R8: With the cascade bit (control-0 bit 6) set, lane 0's control word governs. The count runs as one 16-bit value in which lane 0's carry or borrow steps lane 1 on the same edge, so 00FFh is followed by 0100h.
- R9: With cascade off, each lane wraps on its own. Lane i counting up from FFh to 00h sets `flag_ovf[i]`, counting down from 00h to FFh sets `flag_unf[i]`, and the other lane is unaffected.
- R10: When a step would make a lane's value (or the 16-bit value when cascaded) equal to its compare byte (or word), the matching `flag_match` bit is set. If the match-zero control bit 2 is set, the count becomes 0 instead of the compare value.
- R11: Writing to the acknowledge address (4) clears every flag whose data bit is 1: bit 0/1 clear match 0/1, bits 2/3 clear ovf 0/1, bits 4/5 clear unf 0/1, and bit 6 clears the phase flag. Flags under a 0 bit stay set. Flags stay set until acknowledged.
- R12: Writing to the clear address (3) zeroes lane 0 when data bit 0 is 1 and lane 1 when data bit 1 is 1.
- R13: When cascaded, only the 16-bit wrap sets a flag. FFFFh to 0000h sets `flag_ovf[0]`, 0000h to FFFFh sets `flag_unf[0]`, and lane-1 flags stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 ctrl lane 0, 1 ctrl lane 1, 2 compare, 3 clear, 4 acknowledge |
| wr_data | input | 16 | Write data |
| phase_a | input | 1 | Quadrature phase A |
| phase_b | input | 1 | Quadrature phase B |
| cnt_in | input | 1 | Event count input |
| dir_in | input | 1 | Event direction, 1 = up |
| count | output | 16 | {lane 1, lane 0} count value |
| flag_match | output | 2 | Sticky compare hit per lane |
| flag_ovf | output | 2 | Sticky up-wrap per lane |
| flag_unf | output | 2 | Sticky down-wrap per lane |
| flag_phase | output | 1 | Sticky illegal phase jump |

## Verification
The assertions watch the cascade on every cycle. Whenever the low lane steps, the 16-bit value moves by exactly one, and the high byte holds when no carry or borrow reaches it. They also check that decoded phase steps are never both up and down, that an illegal jump never steps, that wrap and phase events always raise their sticky flags, and that a zero-load leaves a zero count. What the bench scenarios show instead are the decode orderings themselves, the prescaler rate, the three-edge synchronizer latency, compare-and-zero modulo counting and partial acknowledges. These are judged against input sequences whose outcomes are counted by hand.

// File: rtl/updn_pkg.sv
package updn_pkg;

  typedef enum logic [1:0] {
    M_TIMER = 2'd0,
    M_EVENT = 2'd1,
    M_QUAD2 = 2'd2,
    M_QUAD4 = 2'd3
  } cnt_mode_e;

  // control word bits [5:0]; bit 6 (cascade) only exists for lane 0
  typedef struct packed {
    logic [1:0] div;
    logic       run;
    logic       match_zero;
    cnt_mode_e  mode;
  } lane_ctrl_t;

  localparam logic [2:0] A_CTRL0 = 3'd0;
  localparam logic [2:0] A_CTRL1 = 3'd1;
  localparam logic [2:0] A_CMP   = 3'd2;
  localparam logic [2:0] A_CLR   = 3'd3;
  localparam logic [2:0] A_ACK   = 3'd4;
  localparam int CASC_BIT = 6;
  localparam int FLAG_N   = 7;

  // forward Gray step on {a,b}: 00 -> 01 -> 11 -> 10 -> 00
  function automatic logic gray_fwd(input logic [1:0] p, input logic [1:0] n);
    return (p == 2'b00 && n == 2'b01) || (p == 2'b01 && n == 2'b11) ||
           (p == 2'b11 && n == 2'b10) || (p == 2'b10 && n == 2'b00);
  endfunction

  function automatic logic gray_bwd(input logic [1:0] p, input logic [1:0] n);
    return gray_fwd(n, p);
  endfunction

  function automatic logic gray_jump(input logic [1:0] p, input logic [1:0] n);
    return (p ^ n) == 2'b11;
  endfunction

  // returns {up, dn} for a lane given its mode and the decoded events
  function automatic logic [1:0] pick_step(input cnt_mode_e m, input logic run,
                                           input logic tick,
                                           input logic ev_up, input logic ev_dn,
                                           input logic q2_up, input logic q2_dn,
                                           input logic q4_up, input logic q4_dn);
    logic [1:0] r;
    case (m)
      M_TIMER: r = {tick, 1'b0};
      M_EVENT: r = {ev_up, ev_dn};
      M_QUAD2: r = {q2_up, q2_dn};
      default: r = {q4_up, q4_dn};
    endcase
    return run ? r : 2'b00;
  endfunction

endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/updn_phase_decode.sv
module updn_phase_decode import updn_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic a,
  input  logic b,
  input  logic cin,
  input  logic dir,
  output logic ev_up,
  output logic ev_dn,
  output logic q2_up,
  output logic q2_dn,
  output logic q4_up,
  output logic q4_dn,
  output logic q4_err
);
  logic prev_a, prev_b, prev_c;
  logic a_edge, c_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a <= 1'b0;
      prev_b <= 1'b0;
      prev_c <= 1'b0;
    end else begin
      prev_a <= a;
      prev_b <= b;
      prev_c <= cin;
    end
  end

  assign c_rise = cin & ~prev_c;
  assign ev_up  = c_rise & dir;
  assign ev_dn  = c_rise & ~dir;

  assign a_edge = a ^ prev_a;
  assign q2_up  = a_edge & (a == b);
  assign q2_dn  = a_edge & (a != b);

  assign q4_up  = gray_fwd({prev_a, prev_b}, {a, b});
  assign q4_dn  = gray_bwd({prev_a, prev_b}, {a, b});
  assign q4_err = gray_jump({prev_a, prev_b}, {a, b});
endmodule

// File: rtl/updn_prescale.sv
module updn_prescale #(
  parameter int PRE_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic [1:0] div,
  output logic       tick
);
  logic [PRE_W-1:0] presc;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int k = 0; k < PRE_W; k++)
      if (k < 2 * int'(div)) mask[k] = 1'b1;
  end

  assign tick = run && ((presc & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       presc <= '0;
    else if (restart) presc <= '0;
    else if (run)     presc <= presc + 1'b1;
  end
endmodule

// File: rtl/updn_lane.sv
module updn_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  input  logic              zero,
  output logic [LANE_W-1:0] cnt,
  output logic [LANE_W-1:0] stp,
  output logic              carry,
  output logic              borrow
);
  assign stp    = inc ? cnt + 1'b1 : (dec ? cnt - 1'b1 : cnt);
  assign carry  = inc && (cnt == {LANE_W{1'b1}});
  assign borrow = dec && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (zero) cnt <= '0;
    else           cnt <= stp;
  end
endmodule

// File: rtl/updn_counter_unit.sv
module updn_counter_unit import updn_pkg::*; #(
  parameter int LANE_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [2*LANE_W-1:0] wr_data,
  input  logic                phase_a,
  input  logic                phase_b,
  input  logic                cnt_in,
  input  logic                dir_in,
  output logic [2*LANE_W-1:0] count,
  output logic [1:0]          flag_match,
  output logic [1:0]          flag_ovf,
  output logic [1:0]          flag_unf,
  output logic                flag_phase
);
  localparam int CW = 2 * LANE_W;

  // synchronized inputs
  logic [3:0] raw_in, syn_in;
  assign raw_in = {phase_a, phase_b, cnt_in, dir_in};

  updn_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  logic ev_up, ev_dn, q2_up, q2_dn, x4_up, x4_dn, x4_err;

  updn_phase_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .a(syn_in[3]), .b(syn_in[2]), .cin(syn_in[1]), .dir(syn_in[0]),
    .ev_up(ev_up), .ev_dn(ev_dn), .q2_up(q2_up), .q2_dn(q2_dn),
    .q4_up(x4_up), .q4_dn(x4_dn), .q4_err(x4_err)
  );

  // register port
  lane_ctrl_t        ctrl_q [2];
  logic              casc;
  logic [CW-1:0]     cmp_q;
  logic [FLAG_N-1:0] flag_q;
  logic [1:0]        wr_ctrl;
  logic              wr_cmp;
  logic [1:0]        sclr;
  logic [FLAG_N-1:0] ack_mask;

  assign wr_ctrl[0] = wr_en && (wr_addr == A_CTRL0);
  assign wr_ctrl[1] = wr_en && (wr_addr == A_CTRL1);
  assign wr_cmp     = wr_en && (wr_addr == A_CMP);
  assign sclr       = (wr_en && (wr_addr == A_CLR)) ? wr_data[1:0] : 2'b00;
  assign ack_mask   = (wr_en && (wr_addr == A_ACK)) ? wr_data[FLAG_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) ctrl_q[i] <= '0;
      casc  <= 1'b0;
      cmp_q <= '0;
    end else begin
      for (int i = 0; i < 2; i++)
        if (wr_ctrl[i]) ctrl_q[i] <= lane_ctrl_t'(wr_data[5:0]);
      if (wr_ctrl[0]) casc <= wr_data[CASC_BIT];
      if (wr_cmp)     cmp_q <= wr_data;
    end
  end

  // lanes
  logic [1:0]        tick, own_up, own_dn;
  logic [1:0]        lane_inc, lane_dec, lane_zero, lane_carry, lane_borrow;
  logic [1:0]        mhit;
  logic [LANE_W-1:0] cnt [2];
  logic [LANE_W-1:0] stp [2];

  generate
    for (genvar i = 0; i < 2; i++) begin : g_lane
      updn_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(wr_ctrl[i]),
        .run(ctrl_q[i].run), .div(ctrl_q[i].div), .tick(tick[i])
      );

      assign {own_up[i], own_dn[i]} = pick_step(ctrl_q[i].mode, ctrl_q[i].run, tick[i],
                                                ev_up, ev_dn, q2_up, q2_dn, x4_up, x4_dn);

      if (i == 0) begin : g_low
        assign lane_inc[i] = own_up[i];
        assign lane_dec[i] = own_dn[i];
      end else begin : g_high
        assign lane_inc[i] = casc ? lane_carry[0]  : own_up[i];
        assign lane_dec[i] = casc ? lane_borrow[0] : own_dn[i];
      end

      updn_lane #(.LANE_W(LANE_W)) u_lane (
        .clk(clk), .rst_n(rst_n),
        .inc(lane_inc[i]), .dec(lane_dec[i]), .zero(lane_zero[i]),
        .cnt(cnt[i]), .stp(stp[i]),
        .carry(lane_carry[i]), .borrow(lane_borrow[i])
      );

      assign mhit[i] = (lane_inc[i] | lane_dec[i]) &&
                       (stp[i] == cmp_q[i*LANE_W +: LANE_W]);
    end
  endgenerate

  // compare and zero-load
  logic mhit16, mload0, mload1;
  assign mhit16 = (lane_inc[0] | lane_dec[0]) && ({stp[1], stp[0]} == cmp_q);
  assign mload0 = casc ? (mhit16 && ctrl_q[0].match_zero) : (mhit[0] && ctrl_q[0].match_zero);
  assign mload1 = casc ? (mhit16 && ctrl_q[0].match_zero) : (mhit[1] && ctrl_q[1].match_zero);
  assign lane_zero[0] = sclr[0] | mload0;
  assign lane_zero[1] = sclr[1] | mload1;

  // flag events
  logic [1:0] m_ev, o_ev, u_ev;
  logic       phase_ev;
  logic [FLAG_N-1:0] ev_flags;

  assign m_ev[0] = casc ? mhit16 : mhit[0];
  assign m_ev[1] = casc ? 1'b0   : mhit[1];
  assign o_ev[0] = casc ? lane_carry[1]  : lane_carry[0];
  assign o_ev[1] = casc ? 1'b0           : lane_carry[1];
  assign u_ev[0] = casc ? lane_borrow[1] : lane_borrow[0];
  assign u_ev[1] = casc ? 1'b0           : lane_borrow[1];
  assign phase_ev = x4_err &&
                    ((ctrl_q[0].run && ctrl_q[0].mode == M_QUAD4) ||
                     (!casc && ctrl_q[1].run && ctrl_q[1].mode == M_QUAD4));
  assign ev_flags = {phase_ev, u_ev, o_ev, m_ev};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~ack_mask) | ev_flags;
  end

  assign count      = {cnt[1], cnt[0]};
  assign flag_match = flag_q[1:0];
  assign flag_ovf   = flag_q[3:2];
  assign flag_unf   = flag_q[5:4];
  assign flag_phase = flag_q[6];
endmodule

// File: rtl/updn_checker.sv
module updn_checker #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*LANE_W-1:0] count,
  input logic [1:0]          flag_ovf,
  input logic                flag_phase,
  input logic                casc,
  input logic [1:0]          lane_inc,
  input logic [1:0]          lane_dec,
  input logic [1:0]          lane_zero,
  input logic [1:0]          lane_carry,
  input logic [1:0]          lane_borrow,
  input logic                x4_up,
  input logic                x4_dn,
  input logic                x4_err,
  input logic                phase_ev,
  input logic [6:0]          ack_mask
);
  AST_GRAY_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    !(x4_up && x4_dn)); // R5
  AST_JUMP_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    x4_err |-> (!x4_up && !x4_dn)); // R6
  AST_PHASE_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    phase_ev |=> flag_phase); // R6
  AST_CASC_UP_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && lane_inc[0] && lane_zero == 2'b00) |=> (count == $past(count) + 1'b1)); // R8
  AST_CASC_DN_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && lane_dec[0] && lane_zero == 2'b00) |=> (count == $past(count) - 1'b1)); // R8
  AST_CASC_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && !lane_carry[0] && !lane_borrow[0] && !lane_zero[1])
      |=> $stable(count[2*LANE_W-1:LANE_W])); // R8
  AST_LANE_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_carry[0] && !casc) |=> flag_ovf[0]); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovf[0] && !ack_mask[2]) |=> flag_ovf[0]); // R11
  AST_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    lane_zero[0] |=> (count[LANE_W-1:0] == '0)); // R12
endmodule

bind updn_counter_unit updn_checker #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .flag_ovf(flag_ovf),
  .flag_phase(flag_phase), .casc(casc), .lane_inc(lane_inc),
  .lane_dec(lane_dec), .lane_zero(lane_zero), .lane_carry(lane_carry),
  .lane_borrow(lane_borrow), .x4_up(x4_up), .x4_dn(x4_dn),
  .x4_err(x4_err), .phase_ev(phase_ev), .ack_mask(ack_mask)
);

// File: tb/sim_updn_counter_unit.sv
module sim_updn_counter_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        phase_a = 1'b0, phase_b = 1'b0, cnt_in = 1'b0, dir_in = 1'b0;
  logic [15:0] count;
  logic [1:0]  flag_match, flag_ovf, flag_unf;
  logic        flag_phase;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  updn_counter_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phase_a(phase_a), .phase_b(phase_b), .cnt_in(cnt_in), .dir_in(dir_in),
    .count(count), .flag_match(flag_match), .flag_ovf(flag_ovf),
    .flag_unf(flag_unf), .flag_phase(flag_phase)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    phase_a = 0; phase_b = 0; cnt_in = 0; dir_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // run a lane for exactly n clock edges, then stop it
  task automatic run_for(input logic [2:0] a, input logic [15:0] w, input int n);
    wr(a, w);
    repeat (n - 1) @(negedge clk);
    wr(a, 16'h0000);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic set_ph(input logic a, input logic b);
    phase_a = a; phase_b = b; settle();
  endtask

  task automatic pulse();
    cnt_in = 1'b1; settle();
    cnt_in = 1'b0; settle();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count, 0);
    chk("R1 flags", {flag_phase, flag_unf, flag_ovf, flag_match}, 0);
  endtask

  task automatic t_timer();
    do_reset();
    run_for(3'd0, 16'h0008, 7);
    chk("R2 div0 lane0", count, 16'h0007);
    run_for(3'd1, 16'h0008, 3);
    chk("R2 div0 lane1", count, 16'h0307);
    do_reset();
    run_for(3'd0, 16'h0018, 20);
    chk("R2 div1 20 clocks", count, 16'h0005);
  endtask

  task automatic t_event();
    do_reset();
    wr(3'd0, 16'h0009);
    dir_in = 1'b1; settle();
    pulse(); pulse(); pulse();
    chk("R3 up events", count, 3);
    dir_in = 1'b0; settle();
    chk("R3 dir alone", count, 3);
    pulse();
    chk("R3 down event", count, 2);
  endtask

  task automatic t_latency();
    do_reset();
    wr(3'd0, 16'h0009);
    dir_in = 1'b1; settle();
    cnt_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 two edges", count, 0);
    @(negedge clk);
    chk("R7 three edges", count, 1);
    cnt_in = 1'b0; settle();
  endtask

  task automatic t_quad2();
    do_reset();
    wr(3'd0, 16'h000A);
    set_ph(0, 1); set_ph(1, 1); set_ph(1, 0); set_ph(0, 0);
    chk("R4 forward cycle", count, 2);
    set_ph(1, 0);
    chk("R4 reverse A rise", count, 1);
    set_ph(1, 1); set_ph(0, 1); set_ph(0, 0);
    chk("R4 reverse cycle", count, 0);
  endtask

  task automatic t_quad4();
    do_reset();
    wr(3'd0, 16'h000B);
    set_ph(0, 1); set_ph(1, 1); set_ph(1, 0); set_ph(0, 0);
    chk("R5 forward cycle", count, 4);
    set_ph(1, 0); set_ph(1, 1);
    chk("R5 reverse steps", count, 2);
    chk("R5 no phase error", flag_phase, 0);
  endtask

  task automatic t_jump();
    do_reset();
    wr(3'd0, 16'h000B);
    set_ph(1, 1);
    chk("R6 jump count", count, 0);
    chk("R6 jump flag", flag_phase, 1);
    set_ph(0, 0);
    chk("R6 jump back count", count, 0);
  endtask

  task automatic t_cascade();
    do_reset();
    run_for(3'd0, 16'h0048, 255);
    chk("R8 cascade 00FF", count, 16'h00FF);
    run_for(3'd0, 16'h0048, 1);
    chk("R8 cascade 0100", count, 16'h0100);
    chk("R8 no wrap flags", {flag_unf, flag_ovf}, 0);
  endtask

  task automatic t_casc_wrap();
    do_reset();
    wr(3'd0, 16'h0049);
    dir_in = 1'b0; settle();
    pulse();
    chk("R13 down wrap value", count, 16'hFFFF);
    chk("R13 unf flags", flag_unf, 2'b01);
    dir_in = 1'b1; settle();
    pulse();
    chk("R13 up wrap value", count, 16'h0000);
    chk("R13 ovf flags", flag_ovf, 2'b01);
  endtask

  task automatic t_lane_wrap();
    do_reset();
    run_for(3'd0, 16'h0008, 255);
    chk("R9 lane0 at FF", flag_ovf, 0);
    run_for(3'd0, 16'h0008, 1);
    chk("R9 lane0 wrap value", count, 16'h0000);
    chk("R9 lane0 ovf", flag_ovf, 2'b01);
    wr(3'd0, 16'h0009);
    dir_in = 1'b0; settle();
    pulse();
    chk("R9 lane0 down wrap", count, 16'h00FF);
    chk("R9 lane0 unf", flag_unf, 2'b01);
  endtask

  task automatic t_match();
    do_reset();
    wr(3'd2, 16'h0005);
    run_for(3'd0, 16'h000C, 7);
    chk("R10 modulo count", count, 2);
    chk("R10 match flag", flag_match, 2'b01);
    do_reset();
    wr(3'd2, 16'h0003);
    run_for(3'd0, 16'h0008, 5);
    chk("R10 no zero-load", count, 5);
    chk("R10 match kept", flag_match, 2'b01);
  endtask

  task automatic t_ack();
    // continues from t_match state: match0 set
    wr(3'd4, 16'h0002);
    @(negedge clk);
    chk("R11 other bit keeps flag", flag_match, 2'b01);
    wr(3'd4, 16'h0001);
    @(negedge clk);
    chk("R11 ack clears", flag_match, 2'b00);
    chk("R11 count untouched", count, 5);
  endtask

  task automatic t_clear();
    do_reset();
    run_for(3'd0, 16'h0008, 3);
    run_for(3'd1, 16'h0008, 4);
    chk("R12 preload", count, 16'h0403);
    wr(3'd3, 16'h0001);
    chk("R12 clear lane0", count, 16'h0400);
    wr(3'd3, 16'h0002);
    chk("R12 clear lane1", count, 16'h0000);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_timer();
    t_event();
    t_latency();
    t_quad2();
    t_quad4();
    t_jump();
    t_cascade();
    t_casc_wrap();
    t_lane_wrap();
    t_match();
    t_ack();
    t_clear();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule